// File: doc/BRIEF.md
# Byte-wide asynchronous SRAM emulator

This block models a byte-wide static RAM with an asynchronous, pin-level interface, in logic that samples its pins on a clock. It takes an address, a chip select that is active low, a second chip select that is active high, a write strobe and an output-enable strobe. The bidirectional byte bus is split into a data-in byte, a data-out byte and a drive-enable. On every rising clock edge the block decodes the sampled pins into one of four modes: standby, write, read, or selected with the bus idle. It then updates its registered outputs.

Storage is an on-chip array of `2**ADDR_W` bytes. The full part uses `ADDR_W = 18`, which gives 262,144 bytes. The default is a smaller array so that simulation stays fast. The array is split into pages of `2**WORD_W` bytes; the default of 16 bytes matches the full part. The upper address bits pick the page and the low `WORD_W` bits pick the byte within it. The block tracks whether the page used by the last read is still open, and it raises a flag when a read lands in that open page. A write is held while the write strobe stays low, and it is committed to the array when the strobe rises or the chip is deselected.

Top module: `sram_emu`

## Requirements
- R1: Each of the `2**ADDR_W` addresses holds its own byte. A byte written at one address is read back unchanged after every other address has been written.
- R2: When `selLowN` is sampled high or `selHigh` is sampled low, the block is in standby. `dqOe` and `pageHit` are 0 after that edge. The write strobe, output enable, address and data-in have no effect on the stored bytes.
- R3: When the chip is selected and `wrN` is sampled low, `dqOe` is 0 after that edge whatever the value of `rdEnN`, so the bus is never driven during a write.
- R4: A write commits at the first edge that samples `wrN` high or the chip deselected, after one or more edges that sampled the chip selected with `wrN` low. The byte and address used are those sampled at the last edge with `wrN` low.
- R5: When the chip is selected and `wrN` high and `rdEnN` low are sampled, the next cycle has `dqOe` = 1 and `dqOut` equal to the stored byte at the sampled address.
- R6: When the chip is selected with both `wrN` and `rdEnN` sampled high, `dqOe` is 0 and `pageHit` is 0, and the open page stays open.
- R7: A read sampled at the same edge that commits a write to the same address returns the newly written byte.
- R8: Page number is address bits `[ADDR_W-1:WORD_W]`; byte within page is bits `[WORD_W-1:0]`.
- R9: `pageHit` is 1 after a read edge only when the previous read had the same page number and no standby or write edge came between the two reads. The first read after reset, standby or a write gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Asynchronous reset, active low |
| addrIn | input | ADDR_W | Byte address |
| selLowN | input | 1 | Chip select, active low |
| selHigh | input | 1 | Chip select, active high |
| wrN | input | 1 | Write strobe, active low |
| rdEnN | input | 1 | Output enable, active low |
| dIn | input | DATA_W | Byte from the bus |
| dqOut | output | DATA_W | Byte to the bus |
| dqOe | output | 1 | Bus drive enable |
| pageHit | output | 1 | Read stayed inside the open page |

## Verification
Every address is written with a byte computed from the address and then read back in ascending order. This separates address decoding faults from storage faults, and the sequential order also gives a known pattern for the page flag: it is clear at every page boundary and set everywhere else. Directed patterns then check the select combinations, with the inputs toggled during standby, and the two ways a write can end. They also cover a write where the data changes while the strobe is low, a read issued at the same edge as the commit, and reads with an idle cycle, a write, a standby or a page change between them. Each of these gives a different expected value for the page flag.

// File: rtl/sram_emu_pkg.sv
package sram_emu_pkg;

  typedef enum logic [1:0] {
    MODE_STANDBY = 2'd0,
    MODE_WRITE   = 2'd1,
    MODE_READ    = 2'd2,
    MODE_IDLE    = 2'd3
  } emuMode_e;

  // Strobes from control to datapath for the current sampled edge
  typedef struct packed {
    logic captureWr;  // hold address and byte of an ongoing write
    logic commitWr;   // copy the held byte into the array
    logic loadRead;   // load the output byte register
  } memStrobe_t;

endpackage

// File: rtl/sram_emu_ctrl.sv
module sram_emu_ctrl
  import sram_emu_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int WORD_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              selLowN,
  input  logic              selHigh,
  input  logic              wrN,
  input  logic              rdEnN,
  output memStrobe_t        strobe,
  output logic              dqOe,
  output logic              pageHit
);

  localparam int PAGE_W = ADDR_W - WORD_W;

  emuMode_e            mode;
  logic                wrPend;
  logic                pageOpen;
  logic [PAGE_W-1:0]   openPage;
  logic [PAGE_W-1:0]   curPage;
  logic                chipSel;

  assign chipSel = !selLowN && selHigh;
  assign curPage = addrIn[ADDR_W-1:WORD_W];

  always_comb begin
    if (!chipSel)       mode = MODE_STANDBY;
    else if (!wrN)      mode = MODE_WRITE;
    else if (!rdEnN)    mode = MODE_READ;
    else                mode = MODE_IDLE;
  end

  always_comb begin
    strobe.captureWr = (mode == MODE_WRITE);
    strobe.commitWr  = wrPend && (mode != MODE_WRITE);
    strobe.loadRead  = (mode == MODE_READ);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPend   <= 1'b0;
      dqOe     <= 1'b0;
      pageOpen <= 1'b0;
      pageHit  <= 1'b0;
      openPage <= '0;
    end else begin
      wrPend <= (mode == MODE_WRITE);
      dqOe   <= (mode == MODE_READ);
      case (mode)
        MODE_READ: begin
          pageHit  <= pageOpen && (openPage == curPage);
          pageOpen <= 1'b1;
          openPage <= curPage;
        end
        MODE_IDLE: begin
          pageHit <= 1'b0;
        end
        default: begin
          pageHit  <= 1'b0;
          pageOpen <= 1'b0;
        end
      endcase
    end
  end

  // R2
  standby_hiz_chk: assert property (@(posedge clk) disable iff (!rstN)
    (selLowN || !selHigh) |=> (!dqOe && !pageHit));

  // R3
  write_nodrive_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!selLowN && selHigh && !wrN) |=> !dqOe);

  // R5
  read_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!selLowN && selHigh && wrN && !rdEnN) |=> dqOe);

  // R9
  hit_needs_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    pageHit |-> dqOe);

endmodule

// File: rtl/sram_emu_data.sv
module sram_emu_data
  import sram_emu_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  memStrobe_t        strobe,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] dIn,
  output logic [DATA_W-1:0] dqOut
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] memArr [DEPTH];
  logic [ADDR_W-1:0] holdAddr;
  logic [DATA_W-1:0] holdData;
  logic              fwdHit;
  logic [DATA_W-1:0] readByte;

  assign fwdHit   = strobe.commitWr && (holdAddr == addrIn);
  assign readByte = fwdHit ? holdData : memArr[addrIn];

  always_ff @(posedge clk) begin
    if (strobe.commitWr) memArr[holdAddr] <= holdData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdAddr <= '0;
      holdData <= '0;
      dqOut    <= '0;
    end else begin
      if (strobe.captureWr) begin
        holdAddr <= addrIn;
        holdData <= dIn;
      end
      if (strobe.loadRead) dqOut <= readByte;
    end
  end

  // R5
  out_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadRead |=> $stable(dqOut));

  // R3
  wr_rd_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.captureWr, strobe.loadRead}));

endmodule

// File: rtl/sram_emu.sv
module sram_emu
  import sram_emu_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int WORD_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              selLowN,
  input  logic              selHigh,
  input  logic              wrN,
  input  logic              rdEnN,
  input  logic [DATA_W-1:0] dIn,
  output logic [DATA_W-1:0] dqOut,
  output logic              dqOe,
  output logic              pageHit
);

  memStrobe_t strobe;

  sram_emu_ctrl #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .addrIn (addrIn),
    .selLowN(selLowN),
    .selHigh(selHigh),
    .wrN    (wrN),
    .rdEnN  (rdEnN),
    .strobe (strobe),
    .dqOe   (dqOe),
    .pageHit(pageHit)
  );

  sram_emu_data #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) data_i (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .addrIn(addrIn),
    .dIn   (dIn),
    .dqOut (dqOut)
  );

endmodule

// File: tb/sram_emu_tb_top.sv
module sram_emu_tb_top;

  localparam int ADDR_W  = 10;
  localparam int DEPTH   = 1 << ADDR_W;
  localparam time CLK_PER = 10ns;

  logic              clk = 1'b0;
  logic              rstN;
  logic [ADDR_W-1:0] addrIn;
  logic              selLowN, selHigh, wrN, rdEnN;
  logic [7:0]        dIn;
  logic [7:0]        dqOut;
  logic              dqOe, pageHit;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  logic [7:0] shadow [DEPTH];

  always #(CLK_PER/2) clk = ~clk;

  sram_emu #(.ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .selLowN(selLowN),
    .selHigh(selHigh), .wrN(wrN), .rdEnN(rdEnN), .dIn(dIn),
    .dqOut(dqOut), .dqOe(dqOe), .pageHit(pageHit)
  );

  function automatic logic [7:0] pat(int a);
    logic [7:0] v;
    v = 8'(a * 37) ^ 8'(a >> 2) ^ 8'hA5;
    return v;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pins(bit l, bit h, bit w, bit o, int a, logic [7:0] d);
    selLowN = l; selHigh = h; wrN = w; rdEnN = o;
    addrIn = ADDR_W'(a); dIn = d;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic doWrite(int a, logic [7:0] d, bit oe);
    pins(0, 1, 0, oe, a, d);
    tick();
    chk("R3 no drive in write", 32'(dqOe), 0);
    pins(0, 1, 1, 1, a, 8'h00);
    tick();
    shadow[a] = d;
  endtask

  task automatic doRead(string req, int a, bit expHit);
    pins(0, 1, 1, 0, a, 8'h3C);
    tick();
    chk({req, " drive"}, 32'(dqOe), 1);
    chk({req, " data"}, 32'(dqOut), 32'(shadow[a]));
    chk({req, " pageHit"}, 32'(pageHit), 32'(expHit));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0;
    pins(1, 0, 1, 1, 0, 8'h00);
    repeat (3) tick();
    chk("R2 reset dqOe", 32'(dqOe), 0);
    chk("R9 reset pageHit", 32'(pageHit), 0);
    rstN = 1'b1;
    tick();

    // R1 R3: write every address, output enable toggled during writes
    for (int i = 0; i < DEPTH; i++) doWrite(i, pat(i), i[0]);

    // R1 R5 R8 R9: ascending reads, hit everywhere except page starts
    for (int i = 0; i < DEPTH; i++) doRead("R1 R5 R8 R9 sweep", i, (i % 16) != 0);

    // R2: standby with write strobe low and data toggling, both selects
    pins(1, 1, 0, 0, 5, 8'hFF);
    tick();
    chk("R2 standby selLowN dqOe", 32'(dqOe), 0);
    chk("R2 standby selLowN pageHit", 32'(pageHit), 0);
    pins(0, 0, 0, 0, 5, 8'h11);
    tick();
    chk("R2 standby selHigh dqOe", 32'(dqOe), 0);
    pins(1, 0, 1, 1, 5, 8'h22);
    tick();
    doRead("R2 unchanged after standby", 5, 1'b0);

    // R4: write ended by deselect, last sampled byte wins
    pins(0, 1, 0, 1, 40, 8'h17);
    tick();
    pins(0, 1, 0, 0, 40, 8'h6E);
    tick();
    chk("R3 oe ignored in write", 32'(dqOe), 0);
    pins(1, 1, 0, 1, 40, 8'hFF);
    tick();
    shadow[40] = 8'h6E;
    doRead("R4 deselect commit", 40, 1'b0);

    // R4: address change while strobe low uses last sampled address
    pins(0, 1, 0, 1, 70, 8'hC3);
    tick();
    pins(0, 1, 0, 1, 71, 8'hC4);
    tick();
    pins(0, 1, 1, 1, 71, 8'h00);
    tick();
    shadow[71] = 8'hC4;
    doRead("R4 last address 71", 71, 1'b0);
    doRead("R4 address 70 kept", 70, 1'b1);

    // R7: read at the commit edge returns the new byte
    pins(0, 1, 0, 1, 200, 8'h9A);
    tick();
    shadow[200] = 8'h9A;
    doRead("R7 forward", 200, 1'b0);
    doRead("R7 stored", 200, 1'b1);

    // R6: idle cycle keeps the page open
    doRead("R6 open", 48, 1'b0);
    pins(0, 1, 1, 1, 48, 8'h00);
    tick();
    chk("R6 idle dqOe", 32'(dqOe), 0);
    chk("R6 idle pageHit", 32'(pageHit), 0);
    doRead("R6 after idle", 51, 1'b1);

    // R9: write between reads closes the page
    doWrite(300, 8'h5D, 1'b1);
    doRead("R9 after write", 52, 1'b0);

    // R8 R9: neighbouring page misses, back to same page hits
    doRead("R8 next page", 64, 1'b0);
    doRead("R8 previous page", 63, 1'b0);
    doRead("R8 same page", 60, 1'b1);

    // R9: standby between reads closes the page
    pins(1, 1, 1, 0, 61, 8'h00);
    tick();
    doRead("R9 after standby", 61, 1'b0);
    doRead("R1 write 300 kept", 300, 1'b0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule